// File: doc/BRIEF.md
# Rotary Encoder Step and Direction Translator

This block turns the two contact outputs of a mechanical rotary knob into the pair of controls that an up/down-stepped device expects: a direction level and an active-low step strobe. The two knob contacts switch a quarter cycle apart, so the order in which they change tells which way the knob turns. Mechanical contacts bounce, so each input is first brought into the system clock domain and then accepted only once it has held a new level long enough.

The filtered pair of levels is decoded as a four-state Gray sequence. In fine mode every legal state change gives one step. In coarse mode only a full cycle of net movement in one direction gives a step, so a knob resting on one contact edge and jittering across it produces nothing. A state change in which both contacts move at once cannot be decoded. It gives no step and raises a one-cycle error flag. The direction level is settled before each strobe falls, so a receiver that acts on the falling edge always sees the right direction.

Top module: `quad_step_conv`

## Requirements
- R1: While reset is held and after it is released with both inputs low, `step_n_o` is 1, `dir_up_o` is 0 and `illegal_o` is 0.
- R2: A level change on either input that lasts fewer than FILT_CYCLES (default 16) consecutive clock cycles has no effect: no strobe and no error.
- R3: With the state written as the pair (A,B), the sequence 00→01→11→10→00 is the clockwise direction (B changes first). In fine mode (`mode_x4_i`=1) each such step gives exactly one strobe with `dir_up_o`=1.
- R4: In fine mode, each step of the reverse sequence 00→10→11→01→00 gives exactly one strobe with `dir_up_o`=0.
- R5: In coarse mode (`mode_x4_i`=0), a strobe is issued only when the net count of quarter steps reaches four in one direction. A reverse step cancels one forward step, so moving back and forth across one edge gives no strobe.
- R6: `dir_up_o` holds its value in the cycle before `step_n_o` falls and throughout the low phase of the strobe.
- R7: Each strobe holds `step_n_o` at 0 for exactly PULSE_CYCLES (default 4) clock cycles.
- R8: When both filtered inputs change in the same cycle, no strobe results and `illegal_o` is 1 for exactly one cycle.
- R9: Two legal state changes that are accepted one cycle apart both produce strobes, each with its own direction, and none is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a_i | input | 1 | Encoder contact A, asynchronous |
| enc_b_i | input | 1 | Encoder contact B, asynchronous |
| mode_x4_i | input | 1 | 1: a strobe for every state change; 0: a strobe for every full cycle |
| step_n_o | output | 1 | Active-low step strobe; the falling edge is the step event |
| dir_up_o | output | 1 | 1 = up (clockwise), 0 = down |
| illegal_o | output | 1 | One-cycle flag for a transition that changed both contacts |

## Verification
Two functions can land in the same cycle. A new decoded step request can arrive while an earlier strobe is still being issued, and that request must be held and played out afterwards. The bench provokes this by moving contact A and then contact B one clock apart, so the two filters accept them on adjacent cycles. It then judges the result at the ports: two falling edges, the direction seen at each edge, and the width of each low phase. A second collision, both contacts accepted on the same cycle, is judged by the absence of a strobe and by an error flag exactly one cycle long.

// File: rtl/qd_pkg.sv
package qd_pkg;

  typedef enum logic [1:0] {
    SG_IDLE = 2'd0,
    SG_ARM  = 2'd1,
    SG_LOW  = 2'd2,
    SG_GAP  = 2'd3
  } sg_state_e;

  // clockwise successor of a quadrature state {A,B}: 00->01->11->10->00
  function automatic logic [1:0] cw_next(input logic [1:0] s);
    case (s)
      2'b00:   cw_next = 2'b01;
      2'b01:   cw_next = 2'b11;
      2'b11:   cw_next = 2'b10;
      default: cw_next = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/qd_sync_filter.sv
module qd_sync_filter #(
  parameter int FILT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o
);
  localparam int CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == level_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYCLES - 1)) begin
        level_q <= sync_q[1];
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = level_q;

  // a new accepted level always equals the synchronized input that preceded it
  p_filter_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> level_q == $past(sync_q[1]));

endmodule

// File: rtl/qd_decoder.sv
module qd_decoder
  import qd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a_i,
  input  logic b_i,
  input  logic mode_x4_i,
  output logic req_o,
  output logic req_up_o,
  output logic illegal_o
);
  logic [1:0]        prev_q;
  logic [1:0]        cur;
  logic signed [2:0] quarter_q;
  logic              req_q, up_q, ill_q;
  logic              moved, both, is_cw;

  assign cur   = {a_i, b_i};
  assign moved = (cur != prev_q);
  assign both  = &(cur ^ prev_q);
  assign is_cw = (cur == cw_next(prev_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q    <= 2'b00;
      quarter_q <= '0;
      req_q     <= 1'b0;
      up_q      <= 1'b0;
      ill_q     <= 1'b0;
    end else begin
      req_q <= 1'b0;
      ill_q <= 1'b0;
      if (mode_x4_i) quarter_q <= '0;
      if (moved) begin
        prev_q <= cur;
        if (both) begin
          ill_q <= 1'b1;
        end else if (mode_x4_i) begin
          req_q <= 1'b1;
          up_q  <= is_cw;
        end else if (is_cw) begin
          if (quarter_q == 3'sd3) begin
            req_q     <= 1'b1;
            up_q      <= 1'b1;
            quarter_q <= '0;
          end else begin
            quarter_q <= quarter_q + 3'sd1;
          end
        end else begin
          if (quarter_q == -3'sd3) begin
            req_q     <= 1'b1;
            up_q      <= 1'b0;
            quarter_q <= '0;
          end else begin
            quarter_q <= quarter_q - 3'sd1;
          end
        end
      end
    end
  end

  assign req_o     = req_q;
  assign req_up_o  = up_q;
  assign illegal_o = ill_q;

  p_err_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ill_q |=> !ill_q);

  p_err_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ill_q |-> !req_q);

  p_quarter_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (quarter_q <= 3'sd3) && (quarter_q >= -3'sd3));

  p_x4_no_accum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_x4_i) |-> quarter_q == 3'sd0);

endmodule

// File: rtl/qd_step_gen.sv
module qd_step_gen
  import qd_pkg::*;
#(
  parameter int PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic req_up_i,
  output logic step_n_o,
  output logic dir_up_o
);
  localparam int PW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam int RW = $clog2(PULSE_CYCLES + 1);

  sg_state_e     st_q;
  logic [PW-1:0] cnt_q;
  logic          pend_q, pend_up_q, dir_q, step_n_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= SG_IDLE;
      cnt_q     <= '0;
      pend_q    <= 1'b0;
      pend_up_q <= 1'b0;
      dir_q     <= 1'b0;
      step_n_q  <= 1'b1;
    end else begin
      if (st_q == SG_IDLE) begin
        if (pend_q) begin
          dir_q <= pend_up_q;
          st_q  <= SG_ARM;
          if (req_i) begin
            pend_up_q <= req_up_i;
          end else begin
            pend_q <= 1'b0;
          end
        end else if (req_i) begin
          dir_q <= req_up_i;
          st_q  <= SG_ARM;
        end
      end else if (req_i) begin
        pend_q    <= 1'b1;
        pend_up_q <= req_up_i;
      end
      case (st_q)
        SG_ARM: begin
          st_q     <= SG_LOW;
          cnt_q    <= '0;
          step_n_q <= 1'b0;
        end
        SG_LOW: begin
          if (cnt_q == PW'(PULSE_CYCLES - 1)) begin
            step_n_q <= 1'b1;
            st_q     <= SG_GAP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SG_GAP:  st_q <= SG_IDLE;
        default: ;
      endcase
    end
  end

  assign step_n_o = step_n_q;
  assign dir_up_o = dir_q;

  // checker-side run length of the low phase
  logic [RW-1:0] low_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n) low_run_q <= '0;
    else        low_run_q <= step_n_q ? '0 : low_run_q + 1'b1;
  end

  p_dir_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(step_n_q) |-> $stable(dir_q));

  p_dir_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_n_q && $past(!step_n_q)) |-> $stable(dir_q));

  p_low_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_n_q |-> low_run_q < RW'(PULSE_CYCLES));

  p_low_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_n_q) |-> $past(low_run_q) == RW'(PULSE_CYCLES - 1));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && st_q != SG_IDLE) |-> !req_i);

endmodule

// File: rtl/quad_step_conv.sv
module quad_step_conv #(
  parameter int FILT_CYCLES  = 16,
  parameter int PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enc_a_i,
  input  logic enc_b_i,
  input  logic mode_x4_i,
  output logic step_n_o,
  output logic dir_up_o,
  output logic illegal_o
);
  localparam int NCH = 2;

  // a strobe plus its setup and gap must fit between two accepted changes of one contact
  initial begin
    p_param_fit_r9: assert (2 * (PULSE_CYCLES + 2) <= FILT_CYCLES && PULSE_CYCLES >= 1);
  end

  logic [NCH-1:0] raw, lvl;
  logic           req, req_up;

  assign raw = {enc_a_i, enc_b_i};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    qd_sync_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (raw[g]),
      .level_o (lvl[g])
    );
  end

  qd_decoder u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_i       (lvl[1]),
    .b_i       (lvl[0]),
    .mode_x4_i (mode_x4_i),
    .req_o     (req),
    .req_up_o  (req_up),
    .illegal_o (illegal_o)
  );

  qd_step_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req),
    .req_up_i (req_up),
    .step_n_o (step_n_o),
    .dir_up_o (dir_up_o)
  );

  p_reset_idle_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (step_n_o && !illegal_o));

endmodule

// File: tb/quad_step_conv_tb_top.sv
`timescale 1ns/1ps
module quad_step_conv_tb_top;
  localparam int FILT  = 16;
  localparam int PULSE = 4;
  localparam int SETTLE = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, mode_x4 = 1'b1;
  logic step_n, dir_up, illegal;

  always #2 clk = ~clk;

  quad_step_conv #(.FILT_CYCLES(FILT), .PULSE_CYCLES(PULSE)) dut_i (
    .clk(clk), .rst_n(rst_n), .enc_a_i(enc_a), .enc_b_i(enc_b),
    .mode_x4_i(mode_x4), .step_n_o(step_n), .dir_up_o(dir_up),
    .illegal_o(illegal)
  );

  int total = 0, bad = 0;
  int n_fall = 0, n_err = 0, last_width = 0, run = 0;
  logic prev_step = 1'b1, prev_dir = 1'b0, dir_at_fall = 1'b0, fall_dir_a = 1'b0;
  bit done = 0;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // port monitor, sampled on the falling clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_step && !step_n) begin
        n_fall++;
        dir_at_fall = dir_up;
        if (n_fall % 2 == 1) fall_dir_a = dir_up;
        check("R6 dir settled before strobe", dir_up, prev_dir);
      end
      if (!step_n) run++;
      if (!prev_step && step_n) last_width = run;
      if (step_n) run = 0;
      if (!prev_step && !step_n) check("R6 dir held while low", dir_up, prev_dir);
      if (illegal) n_err++;
    end
    prev_step = step_n;
    prev_dir  = dir_up;
  end

  // fields: a, b, x4, steps, dir after, err
  localparam logic [5:0] VEC [21] = '{
    6'b011_1_1_0, 6'b111_1_1_0, 6'b101_1_1_0, 6'b001_1_1_0,   // R3 clockwise, fine
    6'b101_1_0_0, 6'b111_1_0_0, 6'b011_1_0_0, 6'b001_1_0_0,   // R4 reverse, fine
    6'b111_0_0_1,                                             // R8 both change
    6'b101_1_1_0, 6'b001_1_1_0,                               // R3 after error
    6'b010_0_1_0, 6'b000_0_1_0, 6'b010_0_1_0, 6'b110_0_1_0,   // R5 coarse
    6'b100_0_1_0, 6'b000_1_1_0,
    6'b100_0_1_0, 6'b110_0_1_0, 6'b010_0_1_0, 6'b000_1_0_0
  };

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1 step idle in reset", step_n, 1);
    check("R1 dir low in reset", dir_up, 0);
    check("R1 no error in reset", illegal, 0);
    rst_n = 1'b1;
    repeat (SETTLE) @(negedge clk);
    check("R1 step idle after reset", step_n, 1);
    check("R1 dir low after reset", dir_up, 0);
    check("R1 no strobe after reset", n_fall, 0);

    for (int i = 0; i < 21; i++) begin
      int f0, e0;
      f0 = n_fall; e0 = n_err;
      enc_a   = VEC[i][5];
      enc_b   = VEC[i][4];
      mode_x4 = VEC[i][3];
      repeat (SETTLE) @(negedge clk);
      check($sformatf("R3/R4/R5 strobes vec%0d", i), n_fall - f0, VEC[i][2]);
      check($sformatf("R3/R4/R5 dir vec%0d", i), dir_up, VEC[i][1]);
      check($sformatf("R8 error cycles vec%0d", i), n_err - e0, VEC[i][0]);
      if (VEC[i][2]) check($sformatf("R7 low width vec%0d", i), last_width, PULSE);
    end

    // R2: short bounce on A, fine mode, state 00
    begin
      int f0, e0;
      mode_x4 = 1'b1;
      f0 = n_fall; e0 = n_err;
      enc_a = 1'b1;
      repeat (FILT / 2) @(negedge clk);
      enc_a = 1'b0;
      repeat (SETTLE) @(negedge clk);
      check("R2 bounce gives no strobe", n_fall - f0, 0);
      check("R2 bounce gives no error", n_err - e0, 0);
      // R2: bounce on B just under the limit
      enc_b = 1'b1;
      repeat (FILT - 4) @(negedge clk);
      enc_b = 1'b0;
      repeat (SETTLE) @(negedge clk);
      check("R2 near-limit bounce no strobe", n_fall - f0, 0);
    end

    // R9: A then B one cycle apart: 00->10->11, two reverse steps back to back
    begin
      int f0;
      f0 = n_fall;
      enc_a = 1'b1;
      @(negedge clk);
      enc_b = 1'b1;
      repeat (SETTLE) @(negedge clk);
      check("R9 both strobes issued", n_fall - f0, 2);
      check("R9 first strobe dir", fall_dir_a, 0);
      check("R9 second strobe dir", dir_at_fall, 0);
      check("R7 width of queued strobe", last_width, PULSE);
      // R9 with opposite directions: 11->10 (cw) then 10->11 is impossible adjacently;
      // use 11->01 (B... ) reverse then clockwise pair: 11->10 then 10->00
      f0 = n_fall;
      enc_b = 1'b0;
      @(negedge clk);
      enc_a = 1'b0;
      repeat (SETTLE) @(negedge clk);
      check("R9 clockwise pair strobes", n_fall - f0, 2);
      check("R9 clockwise pair dir", dir_at_fall, 1);
    end

    // R1: reset returns outputs to idle
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 dir cleared by reset", dir_up, 0);
    check("R1 step idle under reset", step_n, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    finish_run();
  end
endmodule